// File: doc/BRIEF.md
# Path-History Gated Moore State Machine

This block is a seven-state Moore controller that a single direction bit steers. Its 3-bit output is the code of the state it is in and nothing else. The states are A to G. A is where the machine starts, and G is a terminal state that only reset can leave.

The two branch states, E and F, each offer a way into G. A small history register decides whether that way is open. The register holds the branch state the machine most recently moved out of. It takes a new value only when the machine leaves E or F, and passing through the other states leaves it as it is. So G can be entered from E only after the machine has departed F at some earlier point, and from F only after it has departed E. In other words, both branches must have been visited before the machine can finish.

An asynchronous, active-high reset returns the machine to A and clears the history to A at once. All other changes happen on the rising clock edge.

Top module: `path_gated_fsm`

## Requirements
- R1: While `rst` is high, `state_o` reads 000 (state A), with no clock edge needed. Reset also clears the history register to A.
- R2: `state_o` gives the current state as a code: A=000, B=001, C=010, D=011, E=100, F=101, G=110. The code 111 never appears after reset.
- R3: In A, `dir_i`=1 moves to B and `dir_i`=0 stays in A.
- R4: In B, `dir_i`=1 moves to C and `dir_i`=0 returns to A.
- R5: In C, `dir_i`=1 moves to D and `dir_i`=0 moves to F.
- R6: In D, `dir_i`=1 moves to E and `dir_i`=0 returns to C.
- R7: In E, `dir_i`=0 moves to D. With `dir_i`=1, the machine moves to G if the history holds F, and otherwise stays in E.
- R8: In F, `dir_i`=0 moves to C. With `dir_i`=1, the machine moves to G if the history holds E, and otherwise stays in F.
- R9: The history register loads E or F only on a clock edge that moves the machine out of that state. No other edge changes it. As a result, a path that reaches a branch state without having left the other branch state first cannot enter G.
- R10: Once in G, the machine stays in G for either value of `dir_i` until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset |
| dir_i | input | 1 | Direction bit that selects the outgoing transition |
| state_o | output | 3 | Code of the current state |

## Verification
Every state change, and so every new `state_o` code, appears at the first rising edge after `dir_i` is set up. The only exception is reset, which shows on `state_o` as soon as `rst` rises. The bench therefore changes `dir_i` on a falling edge and reads `state_o` on the next falling edge, so it samples once per transition, half a period after the edge that caused it. The mid-cycle reset check raises `rst` between edges and reads the output one nanosecond later. This shows the return to A does not wait for the clock. The history gate is observed only through whether a final `dir_i`=1 in E or F leads to G or holds the state.

// File: rtl/pgfsm_pkg.sv
package pgfsm_pkg;
  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_A   = 3'd0,
    ST_B   = 3'd1,
    ST_C   = 3'd2,
    ST_D   = 3'd3,
    ST_E   = 3'd4,
    ST_F   = 3'd5,
    ST_G   = 3'd6,
    ST_BAD = 3'd7
  } st_t;

  // True when the machine sits in one branch state and has already left the other.
  function automatic logic gate_fn(st_t cur, st_t hist);
    return ((cur == ST_E) && (hist == ST_F)) || ((cur == ST_F) && (hist == ST_E));
  endfunction

  function automatic logic is_branch(st_t s);
    return (s == ST_E) || (s == ST_F);
  endfunction

  // Transition function; gate says whether a branch state may finish.
  function automatic st_t step_fn(st_t cur, logic dir, logic gate);
    st_t nxt;
    case (cur)
      ST_A:    nxt = dir ? ST_B : ST_A;
      ST_B:    nxt = dir ? ST_C : ST_A;
      ST_C:    nxt = dir ? ST_D : ST_F;
      ST_D:    nxt = dir ? ST_E : ST_C;
      ST_E:    nxt = !dir ? ST_D : (gate ? ST_G : ST_E);
      ST_F:    nxt = !dir ? ST_C : (gate ? ST_G : ST_F);
      ST_G:    nxt = ST_G;
      default: nxt = ST_A;   // illegal encoding recovers to the start state
    endcase
    return nxt;
  endfunction

  function automatic logic [ST_W-1:0] code_of(st_t s);
    return s;
  endfunction
endpackage

// File: rtl/pgfsm_next.sv
module pgfsm_next
  import pgfsm_pkg::*;
(
  input  st_t  cur_i,
  input  logic dir_i,
  input  st_t  hist_i,
  output st_t  nxt_o,
  output logic gate_o
);
  assign gate_o = gate_fn(cur_i, hist_i);
  assign nxt_o  = step_fn(cur_i, dir_i, gate_o);
endmodule

// File: rtl/pgfsm_hist.sv
module pgfsm_hist
  import pgfsm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  st_t  cur_i,
  input  st_t  nxt_i,
  output st_t  hist_o
);
  logic leave_w;
  st_t  hist_q;

  // A branch state is being left on this edge.
  assign leave_w = is_branch(cur_i) && (nxt_i != cur_i);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)          hist_q <= ST_A;
    else if (leave_w) hist_q <= cur_i;
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/pgfsm_outdec.sv
module pgfsm_outdec
  import pgfsm_pkg::*;
(
  input  st_t              cur_i,
  output logic [ST_W-1:0]  code_o
);
  assign code_o = code_of(cur_i);
endmodule

// File: rtl/path_gated_fsm.sv
module path_gated_fsm
  import pgfsm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_i,
  output logic [ST_W-1:0]  state_o
);
  st_t  cur_q;
  st_t  nxt_w;
  st_t  hist_q;
  logic gate_w;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) cur_q <= ST_A;
    else     cur_q <= nxt_w;
  end

  pgfsm_next u_next (
    .cur_i  (cur_q),
    .dir_i  (dir_i),
    .hist_i (hist_q),
    .nxt_o  (nxt_w),
    .gate_o (gate_w)
  );

  pgfsm_hist u_hist (
    .clk    (clk),
    .rst    (rst),
    .cur_i  (cur_q),
    .nxt_i  (nxt_w),
    .hist_o (hist_q)
  );

  pgfsm_outdec u_dec (
    .cur_i  (cur_q),
    .code_o (state_o)
  );
endmodule

// File: rtl/pgfsm_chk.sv
module pgfsm_chk
  import pgfsm_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             dir_i,
  input logic [ST_W-1:0]  code_i,
  input st_t              hist_i,
  input logic             gate_i
);
  assert_reset_to_a_R1: assert property (@(posedge clk) rst |-> (code_i == ST_A && hist_i == ST_A));

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst) code_i != ST_BAD);

  assert_a_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (code_i == ST_A && !dir_i) |=> code_i == ST_A);

  assert_b_back_R4: assert property (@(posedge clk) disable iff (rst)
    (code_i == ST_B && !dir_i) |=> code_i == ST_A);

  assert_c_to_f_R5: assert property (@(posedge clk) disable iff (rst)
    (code_i == ST_C && !dir_i) |=> code_i == ST_F);

  assert_e_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    (code_i == ST_E && dir_i && hist_i != ST_F) |=> code_i == ST_E);

  assert_f_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    (code_i == ST_F && dir_i && hist_i != ST_E) |=> code_i == ST_F);

  assert_finish_R9: assert property (@(posedge clk) disable iff (rst)
    (dir_i && gate_i) |=> code_i == ST_G);

  assert_hist_still_R9: assert property (@(posedge clk) disable iff (rst)
    (code_i != ST_E && code_i != ST_F) |=> $stable(hist_i));

  assert_g_absorbs_R10: assert property (@(posedge clk) disable iff (rst)
    (code_i == ST_G) |=> code_i == ST_G);
endmodule

bind path_gated_fsm pgfsm_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .dir_i  (dir_i),
  .code_i (state_o),
  .hist_i (hist_q),
  .gate_i (gate_w)
);

// File: tb/sim_path_gated_fsm.sv
`timescale 1ns/1ps
module sim_path_gated_fsm;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dir = 1'b0;
  logic [2:0] state;
  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  path_gated_fsm u0 (.clk(clk), .rst(rst), .dir_i(dir), .state_o(state));

  // {dir, expected code after the edge}: the accepted path A B C D E D C F G, then G held
  localparam int NV = 10;
  localparam logic [3:0] PATH [NV] = '{
    {1'b1, 3'b001}, {1'b1, 3'b010}, {1'b1, 3'b011}, {1'b1, 3'b100},
    {1'b0, 3'b011}, {1'b0, 3'b010}, {1'b0, 3'b101}, {1'b1, 3'b110},
    {1'b0, 3'b110}, {1'b1, 3'b110}
  };

  task automatic check(input logic [2:0] exp, input string tag);
    tests++;
    if (state !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, state, exp);
    end
  endtask

  task automatic step(input logic d, input logic [2:0] exp, input string tag);
    dir = d;
    @(negedge clk);
    check(exp, tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check(3'b000, "R1 reset state");
    @(negedge clk);
    rst = 1'b0;

    // stated path via the table
    for (int i = 0; i < NV; i++)
      step(PATH[i][3], PATH[i][2:0], $sformatf("R2 R5 R6 R7 R8 R10 path step %0d", i));

    // asynchronous reset between edges
    #2 rst = 1'b1;
    #1 check(3'b000, "R1 async reset");
    @(negedge clk);
    rst = 1'b0;

    // history cleared by reset: F without E cannot finish
    step(1'b1, 3'b001, "R3 A to B");
    step(1'b1, 3'b010, "R4 B to C");
    step(1'b0, 3'b101, "R5 C to F");
    step(1'b1, 3'b101, "R9 R8 F blocked");
    step(1'b1, 3'b101, "R8 F still blocked");
    step(1'b0, 3'b010, "R8 F to C");
    step(1'b1, 3'b011, "R5 C to D");
    step(1'b1, 3'b100, "R6 D to E");
    step(1'b1, 3'b110, "R7 E to G after F");
    step(1'b0, 3'b110, "R10 G holds");

    // other branch order and remaining edges
    do_reset();
    check(3'b000, "R1 reset from G");
    step(1'b0, 3'b000, "R3 A holds");
    step(1'b1, 3'b001, "R3 A to B");
    step(1'b0, 3'b000, "R4 B to A");
    step(1'b1, 3'b001, "R3 again");
    step(1'b1, 3'b010, "R4 B to C");
    step(1'b1, 3'b011, "R5 C to D");
    step(1'b1, 3'b100, "R6 D to E");
    step(1'b1, 3'b100, "R7 E blocked");
    step(1'b0, 3'b011, "R7 E to D");
    step(1'b0, 3'b010, "R6 D to C");
    step(1'b1, 3'b011, "R5 C to D");
    step(1'b1, 3'b100, "R6 D to E");
    step(1'b1, 3'b100, "R9 E revisit still blocked");
    step(1'b0, 3'b011, "R7 E to D");
    step(1'b0, 3'b010, "R6 D to C");
    step(1'b0, 3'b101, "R5 C to F");
    step(1'b1, 3'b110, "R8 F to G after E");
    step(1'b1, 3'b110, "R10 G holds");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule